// File: doc/BRIEF.md
# Packet Modem Transmit Task Sequencer

This block sits between a host and the bit-serial transmit path of a packet data modem. The host places payload bytes in a four-entry data buffer and writes a 3-bit task code to a command port. The block keeps one task waiting behind the active one. It starts that task on a bit-rate enable pulse and emits one bit on every pulse after that.

Two transmit tasks exist. The first is a continuous scrambler stream, used during channel set-up. The second sends a short block: four payload bytes, a 16-bit CRC, a parity-based FEC placeholder and a row/column interleave, with optional scrambling on top. A reset task stops everything at once. Two status flags, buffer-free and interrupt, tell the host when it may load the next task. Each task has its own rule for those flags.

A waiting task takes over from the active one with no idle bit between them. A scrambler stream is replaced on the very pulse at which the new task emits its first bit. A short block runs to its last bit, and the waiting task then starts on the next pulse.

Top module: `pkt_tx_sequencer`

## Requirements
- R1: After the synchronous reset `rst`, `bfree` is 1, `irq` is 0 and `tx_valid` is 0. A `bit_en` pulse with no task written leaves `tx_valid` at 0.
- R2: Task codes are 0 = null, 1 = reset, 2 = scrambler stream, 3 = short block. Writing code 0 or any of 4 to 7 changes nothing: `bfree` stays as it was and the next `bit_en` emits nothing.
- R3: Writing code 2 or 3 clears `bfree` in the next cycle and fills a single waiting slot. A later write before that task starts replaces the waiting task.
- R4: The scrambler stream task sends the output of a 9-stage LFSR. The LFSR is preset to all ones at each task start, its output is stage 8 and its feedback is stage 8 XOR stage 4, shifted in at stage 0. Starting this task leaves `bfree` and `irq` unchanged.
- R5: While the scrambler stream runs, a waiting task starts on the next `bit_en`, and that pulse emits the new task's first bit in place of a scrambler bit.
- R6: A short block sends 60 bits. Build a message from buffer bytes 0 to 3 (each MSB first), followed by a CRC-16 computed fresh for each block with polynomial 0x1021 and preset 0xFFFF, sent MSB first. Split the message into groups of 4 bits and follow each group with its even-parity bit. This gives coded bits c[0..59]. Transmitted bit k is c[(k mod 5)*12 + k/5].
- R7: If `scr_en` is 1 in the cycle a short block starts, each bit of that block is XORed with the R4 LFSR sequence, restarted from all ones. If `scr_en` is 0, the block is sent unscrambled.
- R8: A short block reads the buffer when it starts. In the cycle after that starting pulse, `bfree` and `irq` are both 1, unless a new task is written in that same cycle, in which case `bfree` is 0.
- R9: A `stat_rd` pulse clears `irq` in the next cycle, unless `irq` is set in that same cycle.
- R10: Writing code 1 acts in the next cycle: `tx_valid` goes to 0, `bfree` goes to 1, the waiting task is dropped and `irq` keeps its value.
- R11: `tx_bit` and `tx_valid` change only after a `bit_en` pulse or a reset task. After the last bit of a short block, the next pulse starts the waiting task without a gap, or clears `tx_valid` if no task is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse per transmit bit period |
| cmd_we | input | 1 | Task code write strobe |
| cmd_task | input | 3 | Task code |
| scr_en | input | 1 | Scramble short blocks, sampled at block start |
| buf_we | input | 1 | Data buffer write strobe |
| buf_addr | input | 2 | Data buffer byte index |
| buf_wdata | input | 8 | Data buffer write byte |
| stat_rd | input | 1 | Host status read strobe, clears irq |
| bfree | output | 1 | Buffer free / next task may be written |
| irq | output | 1 | Interrupt flag |
| tx_bit | output | 1 | Transmit bit |
| tx_valid | output | 1 | tx_bit carries task data |

## Verification
The assertions check a few rules on every cycle:
- the one-cycle effect of a reset task and of a new task on `bfree` and `tx_valid`;
- `tx_bit` and `tx_valid` holding between bit pulses;
- `irq` rising only on a bit pulse and clearing after a status read.

The bench's scenarios are needed for the content of the bit stream: the LFSR sequence, the CRC, parity and interleave order of a short block, the scrambled block, and the gapless handover from a scrambler stream or a finished block to the waiting task. They also show that replacing a waiting task, ignored codes and the reset task's dropping of the waiting slot behave as required at the ports.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam logic [2:0] TK_NULL  = 3'd0;
  localparam logic [2:0] TK_RESET = 3'd1;
  localparam logic [2:0] TK_SCR   = 3'd2;
  localparam logic [2:0] TK_SHORT = 3'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_SCR, ST_SHORT} seq_state_e;
endpackage

// File: rtl/pkt_tx_slot.sv
module pkt_tx_slot (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic push,
  input  logic push_short,
  input  logic pop,
  output logic valid,
  output logic is_short
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid    <= 1'b0;
      is_short <= 1'b0;
    end else if (push) begin
      valid    <= 1'b1;
      is_short <= push_short;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_tx_scram.sv
module pkt_tx_scram #(
  parameter int W   = 9,
  parameter int TAP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic seed,
  input  logic adv,
  output logic out_bit
);
  logic [W-1:0] s_q;
  logic [W-1:0] cur;

  always_comb begin
    cur     = seed ? {W{1'b1}} : s_q;
    out_bit = cur[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) s_q <= {W{1'b1}};
    else if (adv) s_q <= {cur[W-2:0], cur[W-1] ^ cur[TAP-1]};
  end
endmodule

// File: rtl/pkt_tx_frame.sv
module pkt_tx_frame #(
  parameter int            DATA_BYTES = 4,
  parameter int            FEC_GRP    = 4,
  parameter int            ILV_ROWS   = 5,
  parameter logic [15:0]   CRC_POLY   = 16'h1021,
  localparam int DBITS = DATA_BYTES * 8,
  localparam int MBITS = DBITS + 16,
  localparam int NGRP  = MBITS / FEC_GRP,
  localparam int CODED = NGRP * (FEC_GRP + 1),
  localparam int COLS  = CODED / ILV_ROWS
) (
  input  logic [DBITS-1:0] data,
  output logic [CODED-1:0] frame
);
  logic [MBITS-1:0] msg;
  logic [CODED-1:0] coded;
  logic [15:0]      crc;

  always_comb begin
    msg = '0;
    for (int b = 0; b < DATA_BYTES; b++)
      for (int i = 0; i < 8; i++)
        msg[b*8+i] = data[b*8+7-i];
    crc = 16'hFFFF;
    for (int j = 0; j < DBITS; j++) begin
      if (crc[15] ^ msg[j]) crc = {crc[14:0], 1'b0} ^ CRC_POLY;
      else                  crc = {crc[14:0], 1'b0};
    end
    for (int i = 0; i < 16; i++) msg[DBITS+i] = crc[15-i];
    coded = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int i = 0; i < FEC_GRP; i++) begin
        coded[g*(FEC_GRP+1)+i]        = msg[g*FEC_GRP+i];
        coded[g*(FEC_GRP+1)+FEC_GRP] ^= msg[g*FEC_GRP+i];
      end
    end
    for (int k = 0; k < CODED; k++)
      frame[k] = coded[(k % ILV_ROWS) * COLS + k / ILV_ROWS];
  end
endmodule

// File: rtl/pkt_tx_sequencer.sv
module pkt_tx_sequencer #(
  parameter int DATA_BYTES = 4,
  parameter int FEC_GRP    = 4,
  parameter int ILV_ROWS   = 5,
  parameter int SCR_W      = 9,
  parameter int SCR_TAP    = 5,
  localparam int ADDR_W = $clog2(DATA_BYTES),
  localparam int CODED  = ((DATA_BYTES * 8 + 16) / FEC_GRP) * (FEC_GRP + 1),
  localparam int CNT_W  = $clog2(CODED)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              cmd_we,
  input  logic [2:0]        cmd_task,
  input  logic              scr_en,
  input  logic              buf_we,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  input  logic              stat_rd,
  output logic              bfree,
  output logic              irq,
  output logic              tx_bit,
  output logic              tx_valid
);
  import pkt_tx_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODED - 1);

  logic [7:0]              buf_q [DATA_BYTES];
  logic [DATA_BYTES*8-1:0] buf_flat;
  logic [CODED-1:0]        frame_w, frame_q;
  logic [CNT_W-1:0]        cnt;
  seq_state_e              st;
  logic                    scr_mode_q;
  logic                    slot_v, slot_short, scr_bit;
  logic                    rst_cmd, new_cmd, can_start, short_go, scr_adv;

  always_ff @(posedge clk) begin
    if (buf_we) buf_q[buf_addr] <= buf_wdata;
  end

  always_comb begin
    for (int b = 0; b < DATA_BYTES; b++) buf_flat[b*8 +: 8] = buf_q[b];
  end

  assign rst_cmd   = cmd_we && (cmd_task == TK_RESET);
  assign new_cmd   = cmd_we && (cmd_task == TK_SCR || cmd_task == TK_SHORT);
  assign can_start = bit_en && slot_v && (st != ST_SHORT) && !rst_cmd;
  assign short_go  = can_start && slot_short;
  assign scr_adv   = bit_en && !rst_cmd && (can_start || st != ST_IDLE);

  pkt_tx_slot u_slot (
    .clk(clk), .rst(rst), .flush(rst_cmd), .push(new_cmd),
    .push_short(cmd_task == TK_SHORT), .pop(can_start),
    .valid(slot_v), .is_short(slot_short)
  );

  pkt_tx_scram #(.W(SCR_W), .TAP(SCR_TAP)) u_scram (
    .clk(clk), .rst(rst), .seed(can_start), .adv(scr_adv), .out_bit(scr_bit)
  );

  pkt_tx_frame #(.DATA_BYTES(DATA_BYTES), .FEC_GRP(FEC_GRP), .ILV_ROWS(ILV_ROWS)) u_frame (
    .data(buf_flat), .frame(frame_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      frame_q    <= '0;
      scr_mode_q <= 1'b0;
      tx_bit     <= 1'b0;
      tx_valid   <= 1'b0;
      bfree      <= 1'b1;
      irq        <= 1'b0;
    end else if (rst_cmd) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      bfree    <= 1'b1;
      irq      <= irq & ~stat_rd;
    end else begin
      if (short_go)     irq <= 1'b1;
      else if (stat_rd) irq <= 1'b0;
      if (new_cmd)       bfree <= 1'b0;
      else if (short_go) bfree <= 1'b1;
      if (bit_en) begin
        if (can_start) begin
          tx_valid <= 1'b1;
          if (slot_short) begin
            frame_q    <= frame_w;
            scr_mode_q <= scr_en;
            tx_bit     <= frame_w[0] ^ (scr_en & scr_bit);
            cnt        <= CNT_W'(1);
            st         <= ST_SHORT;
          end else begin
            tx_bit <= scr_bit;
            st     <= ST_SCR;
          end
        end else begin
          case (st)
            ST_SCR:   tx_bit <= scr_bit;
            ST_SHORT: begin
              tx_bit <= frame_q[cnt] ^ (scr_mode_q & scr_bit);
              if (cnt == LAST) begin
                cnt <= '0;
                st  <= ST_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default:  tx_valid <= 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_sequencer_chk.sv
module pkt_tx_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic       cmd_we,
  input logic [2:0] cmd_task,
  input logic       stat_rd,
  input logic       bfree,
  input logic       irq,
  input logic       tx_bit,
  input logic       tx_valid
);
  // R10
  rst_task_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_task == 3'd1) |=> (bfree && !tx_valid));

  // R3
  new_task_bfree_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && (cmd_task == 3'd2 || cmd_task == 3'd3)) |=> !bfree);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !(cmd_we && cmd_task == 3'd1)) |=> ($stable(tx_bit) && $stable(tx_valid)));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !bit_en) |=> !irq);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(bit_en));
endmodule

bind pkt_tx_sequencer pkt_tx_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .cmd_we(cmd_we), .cmd_task(cmd_task),
  .stat_rd(stat_rd), .bfree(bfree), .irq(irq), .tx_bit(tx_bit), .tx_valid(tx_valid)
);

// File: tb/pkt_tx_sequencer_tb.sv
module pkt_tx_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, cmd_we = 1'b0, scr_en = 1'b0, buf_we = 1'b0, stat_rd = 1'b0;
  logic [2:0] cmd_task = 3'd0;
  logic [1:0] buf_addr = 2'd0;
  logic [7:0] buf_wdata = 8'd0;
  logic       bfree, irq, tx_bit, tx_valid;
  int         n_chk = 0, n_bad = 0;
  logic [8:0] pn;

  always #5 clk = ~clk;

  pkt_tx_sequencer u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cmd_we(cmd_we), .cmd_task(cmd_task),
    .scr_en(scr_en), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .stat_rd(stat_rd), .bfree(bfree), .irq(irq), .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [59:0] model_frame(input logic [7:0] a0, a1, a2, a3);
    logic [7:0]  by [4];
    logic [47:0] m;
    logic [59:0] c, f;
    logic [15:0] r;
    logic        fb;
    by[0] = a0; by[1] = a1; by[2] = a2; by[3] = a3;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++) m[b*8+i] = by[b][7-i];
    r = 16'hFFFF;
    for (int j = 0; j < 32; j++) begin
      fb = r[15] ^ m[j];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    for (int i = 0; i < 16; i++) m[32+i] = r[15-i];
    for (int g = 0; g < 12; g++) begin
      c[g*5+4] = 1'b0;
      for (int i = 0; i < 4; i++) begin
        c[g*5+i] = m[g*4+i];
        c[g*5+4] = c[g*5+4] ^ m[g*4+i];
      end
    end
    for (int k = 0; k < 60; k++) f[k] = c[(k % 5) * 12 + k / 5];
    return f;
  endfunction

  function automatic logic pn_next();
    logic o;
    o  = pn[8];
    pn = {pn[7:0], pn[8] ^ pn[4]};
    return o;
  endfunction

  task automatic pulse();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] code);
    @(negedge clk) begin cmd_we = 1'b1; cmd_task = code; end
    @(negedge clk) cmd_we = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic load(input logic [7:0] a0, a1, a2, a3);
    logic [7:0] v [4];
    v[0] = a0; v[1] = a1; v[2] = a2; v[3] = a3;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk) begin buf_we = 1'b1; buf_addr = 2'(b); buf_wdata = v[b]; end
    end
    @(negedge clk) buf_we = 1'b0;
  endtask

  task automatic send_frame(string req, logic [59:0] f, logic scr, int first);
    for (int k = first; k < 60; k++) begin
      pulse();
      check(req, {tx_valid, tx_bit}, {1'b1, f[k] ^ (scr & pn_next())});
    end
  endtask

  task automatic t_reset_state();
    check("R1 bfree", bfree, 1);
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    pulse();
    check("R1 idle pulse", tx_valid, 0);
  endtask

  task automatic t_ignored();
    cmd(3'd0); check("R2 null bfree", bfree, 1);
    cmd(3'd5); check("R2 code5 bfree", bfree, 1);
    cmd(3'd7); check("R2 code7 bfree", bfree, 1);
    pulse();   check("R2 no emit", tx_valid, 0);
  endtask

  task automatic t_scram_then_short();
    logic [59:0] f;
    cmd(3'd2);
    check("R3 bfree clear", bfree, 0);
    pn = 9'h1FF;
    for (int k = 0; k < 25; k++) begin
      pulse();
      check("R4 pn bit", {tx_valid, tx_bit}, {1'b1, pn_next()});
    end
    check("R4 irq unchanged", irq, 0);
    check("R4 bfree unchanged", bfree, 0);
    load(8'hA5, 8'h3C, 8'h00, 8'hFF);
    f = model_frame(8'hA5, 8'h3C, 8'h00, 8'hFF);
    cmd(3'd3);
    pulse();
    check("R5 handover first bit", {tx_valid, tx_bit}, {1'b1, f[0]});
    check("R8 bfree", bfree, 1);
    check("R8 irq", irq, 1);
    send_frame("R6 frame", f, 1'b0, 1);
    pulse();
    check("R11 idle after block", tx_valid, 0);
    rd_status();
    check("R9 irq cleared", irq, 0);
  endtask

  task automatic t_scrambled_short();
    logic [59:0] f;
    load(8'h12, 8'h34, 8'h56, 8'h78);
    f = model_frame(8'h12, 8'h34, 8'h56, 8'h78);
    @(negedge clk) scr_en = 1'b1;
    cmd(3'd2);
    cmd(3'd3);
    pn = 9'h1FF;
    pulse();
    check("R3 overwrite started block", irq, 1);
    check("R7 scrambled bit0", tx_bit, f[0] ^ pn_next());
    @(negedge clk) scr_en = 1'b0;
    send_frame("R7 scrambled frame", f, 1'b1, 1);
    rd_status();
  endtask

  task automatic t_back_to_back();
    logic [59:0] fa, fb;
    load(8'hC3, 8'h81, 8'h7E, 8'h01);
    fa = model_frame(8'hC3, 8'h81, 8'h7E, 8'h01);
    fb = model_frame(8'h0F, 8'hF0, 8'h55, 8'hAA);
    cmd(3'd3);
    pulse();
    check("R6 block A bit0", tx_bit, fa[0]);
    load(8'h0F, 8'hF0, 8'h55, 8'hAA);
    cmd(3'd3);
    send_frame("R6 block A", fa, 1'b0, 1);
    send_frame("R11 gapless block B", fb, 1'b0, 0);
    rd_status();
  endtask

  task automatic t_reset_task();
    cmd(3'd3);
    for (int k = 0; k < 10; k++) pulse();
    cmd(3'd2);
    cmd(3'd1);
    check("R10 tx_valid", tx_valid, 0);
    check("R10 bfree", bfree, 1);
    check("R10 irq kept", irq, 1);
    pulse();
    check("R10 pending dropped", tx_valid, 0);
    rd_status();
    check("R9 irq after read", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_ignored();
    t_scram_then_short();
    t_scrambled_short();
    t_back_to_back();
    t_reset_task();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule